// File: doc/BRIEF.md
# Triangular-Carrier Complementary PWM Timer

The block runs an up/down counter that climbs from zero to a programmable period value and then falls back to zero, giving a triangular carrier. Three PWM channels each drive a complementary output pair, a positive phase and a negative phase. A per-channel state bit is set when the counter meets the channel's compare value while rising. It is cleared when they meet while falling. Two further compare channels do not drive pins and only raise match pulses.

Each of the five compare channels has a buffer register. Software may write a buffer at any time. A buffer's value becomes active only at the carrier crest. A new value can therefore take effect between the rising and falling halves of one carrier cycle, and the rising and falling edges of a pulse can come from different values. This gives an asymmetric waveform. A polarity input inverts all six pins and leaves the timing unchanged. The count enable stops and clears the carrier. It does not touch the buffers.

Top module: `tri_pwm`

## Requirements
- R1: After reset, and with `pol_low`=0, `pwm_p` is 000, `pwm_n` is 111 and every pulse output is 0. While enabled, the counter steps 0,1,…,P,P−1,…,0,1,… where P is `period` (P ≥ 1, held stable while enabled).
- R2: `irq_crest` is high for exactly one cycle. It is high in the cycle after the one in which the rising counter equals P.
- R3: `irq_trough` is high for one cycle. It is high in the cycle after the one in which the falling counter reaches 0.
- R4: Buffer writes use `wr_idx` 0–2 for PWM channels 0–2 and 3–4 for pulse channels 0–1. Indices 5–7 are ignored. Every active compare value is loaded from its buffer at the crest, and the crest's own comparison uses the newly loaded value. Buffer writes at any other time do not change the active values.
- R5: A PWM channel's state bit sets when the rising counter (excluding 0 and the crest) equals its compare value. It clears when the falling counter or the crest count equals that value. `pwm_p` reflects the bit one cycle after the match.
- R6: A PWM channel whose loaded value equals P is never set. Its `pwm_p` stays low and its `pwm_n` stays high (with `pol_low`=0).
- R7: A PWM channel whose value is 0 is never set during the cycle.
- R8: `pwm_n` is always the bitwise inverse of `pwm_p`.
- R9: `pol_low`=1 inverts both `pwm_p` and `pwm_n` at once, with the same timing.
- R10: `irq_cmp[j]` pulses for one cycle after each cycle in which the counter equals pulse channel j's compare value, on both the rising and the falling count.
- R11: While `en` is low, the counter clears to 0 and restarts rising, every state bit clears, and all pulses stay low. Buffer contents are kept and are used after enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable; low clears the carrier |
| period | input | W | Crest value P |
| pol_low | input | 1 | 1 selects inverted pin levels |
| wr_en | input | 1 | Buffer write strobe |
| wr_idx | input | 3 | Buffer select (0–2 PWM, 3–4 pulse) |
| wr_data | input | W | Buffer write value |
| pwm_p | output | 3 | Positive-phase pins |
| pwm_n | output | 3 | Negative-phase pins |
| irq_crest | output | 1 | Crest pulse |
| irq_trough | output | 1 | Trough pulse |
| irq_cmp | output | 2 | Pulse-channel match pulses |

## Verification
Mid-range compare values show whether a channel sets on the rising count and clears on the falling count. Values equal to the period and to zero show the no-set corners. Buffer writes made partway up the carrier show whether loading waits for the crest, and whether the falling edge then follows the new value. Random write streams with polarity flips and enable drops, compared every clock against a behavioural model, separate wrong load timing from wrong match timing.

// File: rtl/tri_pwm.sv
module tri_pwm #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] period,
  input  logic         pol_low,
  input  logic         wr_en,
  input  logic [2:0]   wr_idx,
  input  logic [W-1:0] wr_data,
  output logic [2:0]   pwm_p,
  output logic [2:0]   pwm_n,
  output logic         irq_crest,
  output logic         irq_trough,
  output logic [1:0]   irq_cmp
);
  localparam int NCH = 5;
  localparam int NPWM = 3;

  logic [W-1:0] cnt;
  logic         up;
  logic [W-1:0] buf_q [NCH];
  logic [W-1:0] act_q [NCH];
  logic [NPWM-1:0] ff;
  logic [NCH-1:0]  hit;
  logic crest, trough, rise_ok, fall_ok;

  assign crest   = up && (cnt == period);
  assign trough  = !up && (cnt == '0);
  assign rise_ok = up && !crest && (cnt != '0);
  assign fall_ok = !up || crest;

  always_comb
    for (int k = 0; k < NCH; k++)
      hit[k] = (cnt == (crest ? buf_q[k] : act_q[k]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up <= 1'b1;
      ff <= '0;
      irq_crest <= 1'b0;
      irq_trough <= 1'b0;
      irq_cmp <= '0;
      for (int k = 0; k < NCH; k++) begin
        buf_q[k] <= '0;
        act_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NCH; k++)
        if (wr_en && wr_idx == 3'(k)) buf_q[k] <= wr_data;
      if (!en) begin
        cnt <= '0;
        up <= 1'b1;
        ff <= '0;
        irq_crest <= 1'b0;
        irq_trough <= 1'b0;
        irq_cmp <= '0;
      end else begin
        irq_crest <= crest;
        irq_trough <= trough;
        irq_cmp <= hit[4:3];
        if (crest)
          for (int k = 0; k < NCH; k++) act_q[k] <= buf_q[k];
        for (int k = 0; k < NPWM; k++)
          if (hit[k] && rise_ok) ff[k] <= 1'b1;
          else if (hit[k] && fall_ok) ff[k] <= 1'b0;
        if (up) begin
          if (crest) begin
            up <= 1'b0;
            cnt <= (cnt == '0) ? '0 : cnt - 1'b1;
          end else cnt <= cnt + 1'b1;
        end else if (trough) begin
          up <= 1'b1;
          cnt <= (period == '0) ? '0 : W'(1);
        end else cnt <= cnt - 1'b1;
      end
    end
  end

  assign pwm_p = ff ^ {NPWM{pol_low}};
  assign pwm_n = ~ff ^ {NPWM{pol_low}};
endmodule

// File: rtl/tri_pwm_chk.sv
module tri_pwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [W-1:0] period,
  input logic [W-1:0] cnt,
  input logic         up,
  input logic [2:0]   ff,
  input logic         crest,
  input logic [W-1:0] act0,
  input logic [W-1:0] act3,
  input logic         irq_crest,
  input logic         irq_trough,
  input logic [2:0]   pwm_p,
  input logic [2:0]   pwm_n
);
  assert_crest_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crest |=> !irq_crest);
  assert_trough_turns_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_trough |-> up);
  assert_act_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && crest) |=> ($stable(act0) && $stable(act3)));
  assert_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt <= period && period != '0) |=> (!$stable(period) || cnt <= period));
  assert_idle_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ff == 3'b000 && cnt == '0 && !irq_crest && !irq_trough));
  assert_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_n == ~pwm_p);
endmodule

bind tri_pwm tri_pwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .period(period), .cnt(cnt), .up(up),
  .ff(ff), .crest(crest), .act0(act_q[0]), .act3(act_q[3]),
  .irq_crest(irq_crest), .irq_trough(irq_trough), .pwm_p(pwm_p), .pwm_n(pwm_n)
);

// File: tb/test_tri_pwm.sv
module test_tri_pwm;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, pol_low = 1'b0, wr_en = 1'b0;
  logic [W-1:0] period = 16'd10, wr_data = '0;
  logic [2:0] wr_idx = '0;
  logic [2:0] pwm_p, pwm_n;
  logic irq_crest, irq_trough;
  logic [1:0] irq_cmp;
  int checks = 0, errors = 0, cycles = 0;

  int m_cnt = 0, m_up = 1;
  int m_buf [5] = '{default: 0};
  int m_act [5] = '{default: 0};
  int m_ff [3] = '{default: 0};
  int m_crest = 0, m_trough = 0;
  int m_ic [2] = '{default: 0};
  int hi1 = 0, hi2 = 0, hi0 = 0;

  always #2.5 clk = ~clk;

  tri_pwm #(.W(W)) i_tri_pwm (.*);

  always @(posedge clk) begin
    if (rst_n) begin
      if (!en) begin
        m_cnt = 0; m_up = 1; m_crest = 0; m_trough = 0;
        m_ff = '{default: 0}; m_ic = '{default: 0};
      end else begin
        int cr, tr;
        int eff [5];
        cr = (m_up == 1 && m_cnt == int'(period));
        tr = (m_up == 0 && m_cnt == 0);
        for (int k = 0; k < 5; k++) eff[k] = cr ? m_buf[k] : m_act[k];
        for (int k = 0; k < 3; k++)
          if (m_cnt == eff[k]) begin
            if (m_up == 1 && !cr && m_cnt != 0) m_ff[k] = 1;
            else if (m_up == 0 || cr) m_ff[k] = 0;
          end
        for (int j = 0; j < 2; j++) m_ic[j] = (m_cnt == eff[3+j]);
        m_crest = cr; m_trough = tr;
        if (cr) for (int k = 0; k < 5; k++) m_act[k] = m_buf[k];
        if (cr) begin m_up = 0; m_cnt = m_cnt - 1; end
        else if (tr) begin m_up = 1; m_cnt = 1; end
        else if (m_up == 1) m_cnt = m_cnt + 1;
        else m_cnt = m_cnt - 1;
      end
      if (wr_en && wr_idx < 5) m_buf[wr_idx] = int'(wr_data);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int ep;
    cycles++;
    ep = 0;
    for (int k = 0; k < 3; k++) ep[k] = m_ff[k] ^ pol_low;
    chk("R5/R9 pwm_p", int'(pwm_p), ep);
    chk("R8 pwm_n", int'(pwm_n), (~ep) & 7);
    chk("R2 irq_crest", int'(irq_crest), m_crest);
    chk("R3 irq_trough", int'(irq_trough), m_trough);
    chk("R10 irq_cmp", int'(irq_cmp), m_ic[0] + 2 * m_ic[1]);
    if (en && !pol_low) begin
      if (pwm_p[0]) hi0++;
      if (pwm_p[1]) hi1++;
      if (pwm_p[2]) hi2++;
    end
  end

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = W'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pwm_p", int'(pwm_p), 0);
    chk("R1 reset pwm_n", int'(pwm_n), 7);
    wr(0, 3); wr(1, 10); wr(2, 0); wr(3, 4); wr(4, 9); wr(6, 5);
    en = 1'b1;
    run(20);
    hi0 = 0; hi1 = 0; hi2 = 0;
    run(60);
    chk("R6 ch1 never set", hi1, 0);
    chk("R7 ch2 never set", hi2, 0);
    chk("R5 ch0 high cycles", hi0, 42);
    // R4: mid-rise write, falling edge follows new value
    run(3); wr(0, 8); run(40);
    // R11: disable keeps buffers
    en = 1'b0; run(5);
    chk("R11 idle pwm_p", int'(pwm_p), 0);
    en = 1'b1; run(45);
    pol_low = 1'b1; run(30);
    chk("R9 inverted idle", int'(pwm_n[1]), 0);
    pol_low = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) wr($urandom_range(0, 7), $urandom_range(0, 10));
      else run(1);
      if ($urandom_range(0, 60) == 0) begin en = 1'b0; run(2); en = 1'b1; end
      if ($urandom_range(0, 80) == 0) pol_low = ~pol_low;
    end
    run(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule